// File: doc/BRIEF.md
# Flash Completion Poll Controller

This block runs on the host side of a parallel NOR flash and works out when an embedded program or erase has finished and whether it worked. After the host has sent the program or erase command sequence, it pulses `start` with the target word address and the data it wrote. The controller then issues status reads through a simple request/acknowledge read port and interprets the status bits that come back.

Two methods are available, chosen per run by `use_toggle`. The data-poll method compares status bit 7 with bit 7 of the expected data. The toggle method watches status bit 6 flip between back-to-back reads. Both methods use bit 5 as the device's error flag. When bit 5 is seen set, the controller does not fail straight away: it reads again before deciding, because the operation may have ended at the same moment the error flag was sampled.

A failure, whether from the error path or from running out of polls, is followed by one write of the reset code F0h, which returns the device to array read mode. The controller then raises a one-cycle `done` pulse together with the result flags.

Top module: `flash_poll_ctrl`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `pass`, `fail`, `timeout`, `rd_req` and `wr_req` are all 0.
- R2: Each status read is one handshake. `rd_req` stays high with `rd_addr` equal to the `tgt_addr` captured at start until a cycle in which `rd_ack` is high, and `rd_data` is taken in that cycle.
- R3: Data-poll mode (`use_toggle`=0): a read whose bit 7 equals bit 7 of `exp_data` ends the run with `pass`=1, and no write is issued.
- R4: Data-poll mode: a read whose bit 7 differs from the expected bit while bit 5 is 0 leads to another read.
- R5: Data-poll mode: a read with bit 7 mismatching and bit 5 set is followed by exactly one more read. A bit 7 match on that read gives pass, and a mismatch gives fail.
- R6: Toggle mode (`use_toggle`=1): a read whose bit 6 equals bit 6 of the previous read in the same run ends the run with pass. The first read of a run only sets the reference value.
- R7: Toggle mode: a read whose bit 6 differs from the previous read while bit 5 is set is followed by exactly two more reads. The run fails if bit 6 differs between those two reads, and passes otherwise.
- R8: Toggle mode: a read whose bit 6 differs from the previous read while bit 5 is 0 leads to another read.
- R9: If the MAX_POLLS-th loop read still calls for more polling, the run ends with `fail`=1 and `timeout`=1. Loop reads include the first toggle read but not the re-check reads of R5 and R7.
- R10: Every failing run issues exactly one write handshake, with `wr_addr` equal to the target address and `wr_data` equal to F0h, before `done`. A passing run issues no write. `rd_req` and `wr_req` are never high together.
- R11: `done` is high for exactly one cycle per run. At most one of `pass` and `fail` is high, and `timeout` implies `fail`. The flags hold their values after `done` until the next accepted start, and they are 0 while a run is in progress.
- R12: A `start` pulse while `busy` is high is ignored. The run in progress keeps its address, its method and its outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a polling run (accepted only when idle) |
| use_toggle | input | 1 | 1 selects the toggle method, 0 the data-poll method |
| tgt_addr | input | AW | Word address that was programmed or erased |
| exp_data | input | DW | Data written to the target (only bit 7 is compared) |
| rd_req | output | 1 | Status read request |
| rd_addr | output | AW | Status read address |
| rd_ack | input | 1 | Read acknowledge; `rd_data` is valid in this cycle |
| rd_data | input | DW | Status word returned by the device |
| wr_req | output | 1 | Reset-command write request |
| wr_addr | output | AW | Reset-command write address |
| wr_data | output | DW | Reset-command write data (F0h) |
| wr_ack | input | 1 | Write acknowledge |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Operation completed correctly |
| fail | output | 1 | Operation failed or timed out |
| timeout | output | 1 | Poll limit was reached |

## Verification
The status sequences are chosen so that each decision branch is taken on its own. Data-poll runs cover an immediate match, a match after several busy reads, an error flag followed by a late match, and an error flag followed by a mismatch. These separate a correct re-check from an early fail. Toggle runs cover settling without the error flag, settling during the two re-check reads, and toggling that persists through them. These show whether the two confirming reads are compared with each other rather than with the loop read. Both methods are also run with endless busy status to pin the exact read count at which the timeout fires. Read acknowledges arrive after varying delays, and a stray start is injected during a run to show that it changes neither the address nor the outcome.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

   // status bit positions inside a returned status word
   localparam int unsigned POLL_BIT = 7;
   localparam int unsigned TGL_BIT  = 6;
   localparam int unsigned ERR_BIT  = 5;
   localparam int unsigned MIN_DW   = 8;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_READ,
      ST_RESET
   } ctrl_state_e;

   typedef enum logic [1:0] {
      PH_FIRST,
      PH_LOOP,
      PH_CHK_A,
      PH_CHK_B
   } poll_phase_e;

   typedef enum logic [1:0] {
      VD_NEXT,
      VD_CHECK,
      VD_PASS,
      VD_FAIL
   } verdict_e;

endpackage

// File: rtl/fpc_judge.sv
module fpc_judge
   import fpc_pkg::*;
(
   input  logic        toggle_mode,
   input  poll_phase_e phase,
   input  logic        poll_bit,
   input  logic        tgl_bit,
   input  logic        err_bit,
   input  logic        prev_tgl,
   input  logic        exp_bit,
   output verdict_e    verdict
);

   logic poll_match;
   logic tgl_same;

   assign poll_match = (poll_bit == exp_bit);
   assign tgl_same   = (tgl_bit == prev_tgl);

   always_comb begin
      verdict = VD_NEXT;
      if (!toggle_mode) begin
         unique case (phase)
            PH_CHK_A, PH_CHK_B: verdict = poll_match ? VD_PASS : VD_FAIL;
            default: begin
               if (poll_match)   verdict = VD_PASS;
               else if (err_bit) verdict = VD_CHECK;
               else              verdict = VD_NEXT;
            end
         endcase
      end else begin
         unique case (phase)
            PH_FIRST: verdict = VD_NEXT;
            PH_LOOP: begin
               if (tgl_same)     verdict = VD_PASS;
               else if (err_bit) verdict = VD_CHECK;
               else              verdict = VD_NEXT;
            end
            PH_CHK_A: verdict = VD_CHECK;
            PH_CHK_B: verdict = tgl_same ? VD_PASS : VD_FAIL;
            default:  verdict = VD_NEXT;
         endcase
      end
   end

endmodule

// File: rtl/fpc_poll_cnt.sv
module fpc_poll_cnt #(
   parameter int unsigned MAX_POLLS = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic last
);

   localparam int unsigned CW = $clog2(MAX_POLLS);
   localparam logic [CW-1:0] LAST_VAL = CW'(MAX_POLLS - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (inc && !last) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign last = (cnt_q == LAST_VAL);

endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
   import fpc_pkg::*;
#(
   parameter int unsigned AW        = 23,
   parameter int unsigned DW        = 16,
   parameter int unsigned MAX_POLLS = 4096,
   parameter logic [7:0]  RST_CODE  = 8'hF0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          use_toggle,
   input  logic [AW-1:0] tgt_addr,
   input  logic [DW-1:0] exp_data,
   output logic          rd_req,
   output logic [AW-1:0] rd_addr,
   input  logic          rd_ack,
   input  logic [DW-1:0] rd_data,
   output logic          wr_req,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data,
   input  logic          wr_ack,
   output logic          busy,
   output logic          done,
   output logic          pass,
   output logic          fail,
   output logic          timeout
);

   localparam logic [DW-1:0] RST_WORD = DW'(RST_CODE);

   // elaboration-time parameter checks
   generate
      if (DW < MIN_DW) begin : g_bad_dw
         $error("flash_poll_ctrl: DW must be at least 8");
      end
      if (MAX_POLLS < 2) begin : g_bad_polls
         $error("flash_poll_ctrl: MAX_POLLS must be at least 2");
      end
      if (AW < 1) begin : g_bad_aw
         $error("flash_poll_ctrl: AW must be at least 1");
      end
   endgenerate

   ctrl_state_e state_q;
   poll_phase_e phase_q;
   logic [AW-1:0] addr_q;
   logic          exp_bit_q;
   logic          mode_q;
   logic          prev_tgl_q;
   logic          tmo_pend_q;
   logic          done_q, pass_q, fail_q, tmo_q;

   verdict_e verdict;
   logic     cnt_last;
   logic     accept;
   logic     rd_fire;
   logic     wr_fire;

   assign accept  = (state_q == ST_IDLE) && start;
   assign rd_fire = (state_q == ST_READ) && rd_ack;
   assign wr_fire = (state_q == ST_RESET) && wr_ack;

   // status bits of the word just returned
   fpc_judge i_judge (
      .toggle_mode (mode_q),
      .phase       (phase_q),
      .poll_bit    (rd_data[POLL_BIT]),
      .tgl_bit     (rd_data[TGL_BIT]),
      .err_bit     (rd_data[ERR_BIT]),
      .prev_tgl    (prev_tgl_q),
      .exp_bit     (exp_bit_q),
      .verdict     (verdict)
   );

   fpc_poll_cnt #(
      .MAX_POLLS (MAX_POLLS)
   ) i_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (accept),
      .inc   (rd_fire && (verdict == VD_NEXT)),
      .last  (cnt_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         phase_q    <= PH_FIRST;
         addr_q     <= '0;
         exp_bit_q  <= 1'b0;
         mode_q     <= 1'b0;
         prev_tgl_q <= 1'b0;
         tmo_pend_q <= 1'b0;
         done_q     <= 1'b0;
         pass_q     <= 1'b0;
         fail_q     <= 1'b0;
         tmo_q      <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  addr_q     <= tgt_addr;
                  exp_bit_q  <= exp_data[POLL_BIT];
                  mode_q     <= use_toggle;
                  phase_q    <= PH_FIRST;
                  tmo_pend_q <= 1'b0;
                  pass_q     <= 1'b0;
                  fail_q     <= 1'b0;
                  tmo_q      <= 1'b0;
                  state_q    <= ST_READ;
               end
            end
            ST_READ: begin
               if (rd_ack) begin
                  prev_tgl_q <= rd_data[TGL_BIT];
                  unique case (verdict)
                     VD_PASS: begin
                        done_q  <= 1'b1;
                        pass_q  <= 1'b1;
                        state_q <= ST_IDLE;
                     end
                     VD_FAIL: begin
                        state_q <= ST_RESET;
                     end
                     VD_CHECK: begin
                        phase_q <= (phase_q == PH_CHK_A) ? PH_CHK_B : PH_CHK_A;
                     end
                     default: begin
                        if (cnt_last) begin
                           tmo_pend_q <= 1'b1;
                           state_q    <= ST_RESET;
                        end else begin
                           phase_q <= PH_LOOP;
                        end
                     end
                  endcase
               end
            end
            ST_RESET: begin
               if (wr_ack) begin
                  done_q  <= 1'b1;
                  fail_q  <= 1'b1;
                  tmo_q   <= tmo_pend_q;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign rd_req  = (state_q == ST_READ);
   assign rd_addr = addr_q;
   assign wr_req  = (state_q == ST_RESET);
   assign wr_addr = addr_q;
   assign wr_data = RST_WORD;
   assign busy    = (state_q != ST_IDLE);
   assign done    = done_q;
   assign pass    = pass_q;
   assign fail    = fail_q;
   assign timeout = tmo_q;

   // bits of the data words that the decision does not use
   logic unused_low;
   assign unused_low = ^{rd_data[ERR_BIT-1:0], exp_data[POLL_BIT-1:0], rd_fire, wr_fire};
   generate
      if (DW > MIN_DW) begin : g_wide
         logic unused_high;
         assign unused_high = ^{rd_data[DW-1:MIN_DW], exp_data[DW-1:MIN_DW]};
      end
   endgenerate

endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
   parameter int unsigned AW = 23,
   parameter int unsigned DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          rd_req,
   input logic [AW-1:0] rd_addr,
   input logic          rd_ack,
   input logic          wr_req,
   input logic [DW-1:0] wr_data,
   input logic          wr_ack,
   input logic          busy,
   input logic          done,
   input logic          pass,
   input logic          fail,
   input logic          timeout
);

   p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

   p_pass_nowrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && pass) |-> !$past(wr_req));

   p_tmo_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |-> fail);

   p_fail_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fail) |-> $past(wr_req && wr_ack));

   p_wr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_ack) |=> (wr_req && $stable(wr_data)));

   p_port_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req && wr_req));

   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_result_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pass, fail}));

   p_flags_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable({pass, fail, timeout}));

   p_busy_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ({pass, fail, timeout} == 3'b000));

   p_start_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(rd_addr));

endmodule

bind flash_poll_ctrl fpc_checker #(
   .AW (AW),
   .DW (DW)
) i_fpc_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .rd_req  (rd_req),
   .rd_addr (rd_addr),
   .rd_ack  (rd_ack),
   .wr_req  (wr_req),
   .wr_data (wr_data),
   .wr_ack  (wr_ack),
   .busy    (busy),
   .done    (done),
   .pass    (pass),
   .fail    (fail),
   .timeout (timeout)
);

// File: tb/test_flash_poll_ctrl.sv
module test_flash_poll_ctrl;

   localparam int AW   = 12;
   localparam int DW   = 16;
   localparam int MAXP = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          use_toggle = 1'b0;
   logic [AW-1:0] tgt_addr = '0;
   logic [DW-1:0] exp_data = '0;
   logic          rd_req;
   logic [AW-1:0] rd_addr;
   logic          rd_ack = 1'b0;
   logic [DW-1:0] rd_data = '0;
   logic          wr_req;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;
   logic          wr_ack = 1'b0;
   logic          busy, done, pass, fail, timeout;

   always #10 clk = ~clk;

   flash_poll_ctrl #(
      .AW        (AW),
      .DW        (DW),
      .MAX_POLLS (MAXP)
   ) i_flash_poll_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .use_toggle (use_toggle),
      .tgt_addr   (tgt_addr),
      .exp_data   (exp_data),
      .rd_req     (rd_req),
      .rd_addr    (rd_addr),
      .rd_ack     (rd_ack),
      .rd_data    (rd_data),
      .wr_req     (wr_req),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .wr_ack     (wr_ack),
      .busy       (busy),
      .done       (done),
      .pass       (pass),
      .fail       (fail),
      .timeout    (timeout)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   logic [DW-1:0] resp [0:15];

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   // behavioural reference: walks the scripted status words
   task automatic model(input bit tg, input bit e7, input int n,
                        output bit mp, output bit mf, output bit mt, output int nr);
      int i = 0;
      int loops = 0;
      bit prev6 = 1'b0;
      logic [DW-1:0] d, a, b;
      mp = 0; mf = 0; mt = 0;
      while (1) begin
         d = resp[(i < n) ? i : n-1]; i++;
         if (!tg) begin
            if (d[7] == e7) begin mp = 1; break; end
            if (d[5]) begin
               a = resp[(i < n) ? i : n-1]; i++;
               if (a[7] == e7) mp = 1; else mf = 1;
               break;
            end
         end else begin
            if (loops > 0 && d[6] == prev6) begin mp = 1; break; end
            if (loops > 0 && d[5]) begin
               a = resp[(i < n) ? i : n-1]; i++;
               b = resp[(i < n) ? i : n-1]; i++;
               if (a[6] != b[6]) mf = 1; else mp = 1;
               break;
            end
            prev6 = d[6];
         end
         loops++;
         if (loops == MAXP) begin mf = 1; mt = 1; break; end
      end
      nr = i;
   endtask

   task automatic run(input string req, input bit tg, input logic [DW-1:0] ed,
                      input logic [AW-1:0] ad, input int n, input bit disturb);
      bit mp, mf, mt;
      int mr;
      int nrd = 0, nwr = 0, rwait = 0, wwait = 0, ndone = 0, after = 0;
      bit seen = 0;
      bit gp = 0, gf = 0, gt = 0;
      model(tg, ed[7], n, mp, mf, mt, mr);
      @(negedge clk);
      start = 1'b1; use_toggle = tg; exp_data = ed; tgt_addr = ad;
      @(negedge clk);
      start = 1'b0;
      for (int cyc = 0; cyc < 400; cyc++) begin
         if (done) begin
            ndone++;
            if (!seen) begin gp = pass; gf = fail; gt = timeout; end
            seen = 1;
         end else if (!seen) begin
            check({pass, fail, timeout} == 3'b000, "R11", {req, " flags during run"},
                  {pass, fail, timeout}, 0);
         end else begin
            after++;
            check({pass, fail, timeout} == {mp, mf, mt}, "R11", {req, " flags held"},
                  {pass, fail, timeout}, {mp, mf, mt});
         end
         if (rd_req)
            check(rd_addr == ad, disturb ? "R12" : "R2", {req, " read address"},
                  rd_addr, ad);
         if (rd_req && wr_req)
            check(0, "R10", {req, " read and write together"}, 1, 0);
         if (wr_req && !wr_ack) begin
            check(wr_addr == ad, "R10", {req, " write address"}, wr_addr, ad);
            check(wr_data == DW'(8'hF0), "R10", {req, " write data"}, wr_data, 'hF0);
         end
         if (disturb && cyc == 2) begin
            start = 1'b1; tgt_addr = ~ad; use_toggle = ~tg; exp_data = ~ed;
         end
         if (disturb && cyc == 3) start = 1'b0;
         // read responder, latency varies with the read index
         if (rd_ack) begin
            rd_ack = 1'b0; rwait = 0;
         end else if (rd_req) begin
            if (rwait >= (nrd % 3)) begin
               rd_ack = 1'b1;
               rd_data = resp[(nrd < n) ? nrd : n-1];
               nrd++;
            end else rwait++;
         end
         // write responder, one idle cycle
         if (wr_ack) begin
            wr_ack = 1'b0; wwait = 0;
         end else if (wr_req) begin
            if (wwait >= 1) begin wr_ack = 1'b1; nwr++; end
            else wwait++;
         end
         if (after >= 2) break;
         @(negedge clk);
      end
      check(ndone == 1, "R11", {req, " done pulses"}, ndone, 1);
      check(gp == mp, req, {req, " pass flag"}, gp, mp);
      check(gf == mf, mt ? "R9" : req, {req, " fail flag"}, gf, mf);
      check(gt == mt, "R9", {req, " timeout flag"}, gt, mt);
      check(nrd == mr, req, {req, " reads issued"}, nrd, mr);
      check(nwr == (mf ? 1 : 0), "R10", {req, " reset writes"}, nwr, mf ? 1 : 0);
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check({busy, done, pass, fail, timeout, rd_req, wr_req} == 7'b0, "R1",
            "outputs in reset", {busy, done, pass, fail, timeout, rd_req, wr_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check({busy, done, pass, fail, timeout, rd_req, wr_req} == 7'b0, "R1",
            "outputs after reset", {busy, done, pass, fail, timeout, rd_req, wr_req}, 0);

      // R3: immediate match
      resp[0] = 16'h0000;
      run("R3", 0, 16'h0000, 12'h123, 1, 0);
      // R4: busy reads then match
      resp[0] = 16'h0000; resp[1] = 16'h0001; resp[2] = 16'h0080;
      run("R4", 0, 16'h0080, 12'h200, 3, 0);
      // R5: error flag then late match
      resp[0] = 16'h0000; resp[1] = 16'h0020; resp[2] = 16'h0080;
      run("R5", 0, 16'h0080, 12'h0F0, 3, 0);
      // R5: error flag then mismatch
      resp[0] = 16'h0020; resp[1] = 16'h0020;
      run("R5", 0, 16'h0080, 12'h3A5, 2, 0);
      // R9: data-poll never completes
      for (int k = 0; k < 8; k++) resp[k] = 16'h0000;
      run("R9", 0, 16'h0080, 12'h011, 8, 0);
      // R6 and R8: toggling then settled, with a stray start (R12)
      resp[0] = 16'h0040; resp[1] = 16'h0000; resp[2] = 16'h0040; resp[3] = 16'h0040;
      run("R8", 1, 16'h0000, 12'h456, 4, 1);
      // R6: settled at second read
      resp[0] = 16'h00C0; resp[1] = 16'h0040;
      run("R6", 1, 16'h0000, 12'h457, 2, 0);
      // R7: error flag, settles during re-check
      resp[0] = 16'h0000; resp[1] = 16'h0060; resp[2] = 16'h0040; resp[3] = 16'h0040;
      run("R7", 1, 16'h0000, 12'h777, 4, 0);
      // R7: error flag, still toggling
      resp[0] = 16'h0000; resp[1] = 16'h0060; resp[2] = 16'h0000; resp[3] = 16'h0040;
      run("R7", 1, 16'h0000, 12'h778, 4, 0);
      // R9: toggle never settles
      for (int k = 0; k < 8; k++) resp[k] = (k % 2 == 0) ? 16'h0000 : 16'h0040;
      run("R9", 1, 16'h0000, 12'h999, 8, 0);

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule